// File: doc/BRIEF.md
# Branch Target Cache

This block sits beside the fetch address register and predicts simple direct branches that have been taken before. It keeps a direct-mapped table. Each entry pairs the word address of a branch with the word address it jumped to. When the branch retires, the execute stage writes the entry for that branch: a taken outcome makes the entry live and a not-taken outcome kills it. While fetch walks straight-line code, the block watches the address stream. When the instruction now being fetched is a live branch in the table, it asks fetch to jump to the stored target next and marks that fetch as predicted taken. The decode stage then leaves that instruction alone.

To keep the table read off the critical path, the lookup runs two instructions ahead. Each accepted fetch reads the entry for its address plus 8 into a register, the tag is compared in the next cycle, and the hit is used on the fetch after that. A stream therefore needs two fetches of history before it can be predicted. This applies after an external redirect and after the block's own jump. When fetch stalls, the pipeline holds its state.

Top module: `branch_target_predictor`

## Requirements
- R1: Addresses are byte addresses with bits 1:0 zero. The entry index is address bits IDX_W+1:2, and an entry hits only when all address bits above the index equal those of the branch that wrote it. A fetch that shares the index but differs in any upper bit is never redirected.
- R2: After reset every entry is dead, so no fetch is redirected until a taken update has been made.
- R3: An update with `resolve_taken`=1 makes the entry at the branch's index live with that branch and target. An update with `resolve_taken`=0 writes the entry as dead, which stops later redirects for that branch.
- R4: When a fetch of a live branch address is eligible (R5, R6), `redir_req` is 1 in that same cycle and `redir_pc` equals the stored target.
- R5: A fetch with `fetch_restart`=1 and the next accepted fetch are never redirected. The third and later sequential fetches may be.
- R6: The fetch of a target the block itself redirected to, and the fetch after it, are never redirected. The third sequential fetch from that target may be.
- R7: While `fetch_vld` is 0, `redir_req` is 0 and the lookahead state is held. Predictions on the stream continue as though no stall cycles had occurred.
- R8: `pred_taken` is 1 for exactly the accepted fetches that the block redirects and 0 for all others.
- R9: If an update to an index happens in the same cycle as the lookahead read of that index, the read sees the contents from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_vld | input | 1 | A fetch address is issued and accepted this cycle |
| fetch_restart | input | 1 | This fetch starts a new stream after an external redirect |
| fetch_pc | input | ADDR_W | Byte address of the instruction being fetched |
| resolve_vld | input | 1 | A simple branch resolved in execute this cycle |
| resolve_pc | input | ADDR_W | Byte address of the resolved branch |
| resolve_taken | input | 1 | The resolved branch was taken |
| resolve_tgt | input | ADDR_W | Byte address of the branch target |
| redir_req | output | 1 | Fetch must continue at `redir_pc` after this fetch |
| redir_pc | output | ADDR_W | Predicted target byte address |
| pred_taken | output | 1 | Flag carried with the current fetch: it was predicted taken |

## Verification
The bench builds the block with a 16-bit address and a 3-bit index, so the table has eight entries. This is small enough to place a taken branch at every slot of a short stream and to alias it from several upper-address values. Every stream offset relative to a restart and to a self-redirect is therefore reached. Stall cycles are inserted between fetches. Updates are timed to land in the cycle before, and in the same cycle as, the lookahead read. The expected redirects come from a two-deep snapshot model of the table kept in the bench.

// File: rtl/brcache_pkg.sv
package brcache_pkg;
  localparam int unsigned DEF_ADDR_W      = 32;
  localparam int unsigned DEF_IDX_W       = 10;
  // Lookahead distance, in instructions, between the fetch and the entry read for it.
  localparam int unsigned LOOKAHEAD_INSNS = 2;

  typedef enum logic [1:0] {
    EV_SEQ      = 2'd0,
    EV_RESTART  = 2'd1,
    EV_SELF_JMP = 2'd2,
    EV_STALL    = 2'd3
  } stream_ev_e;
endpackage

// File: rtl/brcache_store.sv
module brcache_store #(
  parameter int unsigned IDX_W = 10,
  parameter int unsigned TAG_W = 20,
  parameter int unsigned TGT_W = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [TGT_W-1:0] wr_tgt,
  input  logic             wr_live,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_live,
  output logic [TAG_W-1:0] rd_tag,
  output logic [TGT_W-1:0] rd_tgt
);
  localparam int unsigned ENTRIES = 1 << IDX_W;

  logic [ENTRIES-1:0] live_q;
  logic [ENTRIES-1:0] wr_dec;
  logic [TAG_W-1:0]   tag_mem [ENTRIES];
  logic [TGT_W-1:0]   tgt_mem [ENTRIES];
  logic               rd_live_q;
  logic [TAG_W-1:0]   rd_tag_q;
  logic [TGT_W-1:0]   rd_tgt_q;
  logic               wr_seen_q;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_dec
    assign wr_dec[e] = wr_en && (wr_idx == IDX_W'(e));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q    <= '0;
      wr_seen_q <= 1'b0;
    end else begin
      live_q <= (live_q & ~wr_dec) | (wr_dec & {ENTRIES{wr_live}});
      if (wr_en) wr_seen_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx] <= wr_tag;
      tgt_mem[wr_idx] <= wr_tgt;
    end
  end

  // Registered read: a write at the same edge is not visible to this read.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_live_q <= 1'b0;
      rd_tag_q  <= '0;
      rd_tgt_q  <= '0;
    end else if (rd_en) begin
      rd_live_q <= live_q[rd_idx];
      rd_tag_q  <= tag_mem[rd_idx];
      rd_tgt_q  <= tgt_mem[rd_idx];
    end
  end

  assign rd_live = rd_live_q;
  assign rd_tag  = rd_tag_q;
  assign rd_tgt  = rd_tgt_q;

  AST_EMPTY_UNTIL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_seen_q |-> (live_q == '0)); // R2
  AST_TAKEN_MAKES_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_live) |=> live_q[$past(wr_idx)]); // R3
  AST_NOT_TAKEN_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_live) |=> !live_q[$past(wr_idx)]); // R3
  AST_READ_SEES_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wr_en && rd_idx == wr_idx) |=> (rd_live_q == $past(live_q[rd_idx]))); // R9
endmodule

// File: rtl/brcache_lookahead.sv
module brcache_lookahead
  import brcache_pkg::*;
#(
  parameter int unsigned WORD_W = 30,
  parameter int unsigned IDX_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              f_valid,
  input  logic              f_restart,
  input  logic [WORD_W-1:0] f_word,
  output logic              rd_en,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic              rd_live,
  input  logic [WORD_W-IDX_W-1:0] rd_tag,
  input  logic [WORD_W-1:0] rd_tgt,
  output logic              jump,
  output logic [WORD_W-1:0] jump_word
);
  localparam int unsigned TAG_W = WORD_W - IDX_W;

  function automatic logic [WORD_W-1:0] ahead_of(input logic [WORD_W-1:0] w);
    return w + WORD_W'(LOOKAHEAD_INSNS);
  endfunction
  function automatic logic [IDX_W-1:0] index_of(input logic [WORD_W-1:0] w);
    return w[IDX_W-1:0];
  endfunction
  function automatic logic [TAG_W-1:0] tag_of(input logic [WORD_W-1:0] w);
    return w[WORD_W-1:IDX_W];
  endfunction

  logic [WORD_W-1:0] la_word;
  logic              s1_vld_q;
  logic [TAG_W-1:0]  s1_tag_q;
  logic              s2_vld_q;
  logic              s2_hit_q;
  logic [WORD_W-1:0] s2_tgt_q;
  logic              s1_hit;
  logic              fire;
  logic              kill;
  stream_ev_e        ev;

  assign la_word = ahead_of(f_word);
  assign rd_en   = f_valid;
  assign rd_idx  = index_of(la_word);

  // Stage 1 -> 2: tag compare on the entry read in the previous accepted fetch.
  assign s1_hit = rd_live && (rd_tag == s1_tag_q);

  // Stage 2: decision for the fetch issued now.
  assign fire = f_valid && !f_restart && s2_vld_q && s2_hit_q;
  assign kill = f_restart || fire;

  always_comb begin
    if (!f_valid)       ev = EV_STALL;
    else if (f_restart) ev = EV_RESTART;
    else if (fire)      ev = EV_SELF_JMP;
    else                ev = EV_SEQ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld_q <= 1'b0;
      s1_tag_q <= '0;
      s2_vld_q <= 1'b0;
      s2_hit_q <= 1'b0;
      s2_tgt_q <= '0;
    end else if (f_valid) begin
      s1_vld_q <= !fire;
      s1_tag_q <= tag_of(la_word);
      s2_vld_q <= s1_vld_q && !kill;
      s2_hit_q <= s1_hit;
      s2_tgt_q <= rd_tgt;
    end
  end

  assign jump      = fire;
  assign jump_word = s2_tgt_q;

  AST_RESTART_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_RESTART) |=> !s2_vld_q); // R5
  AST_SELF_JUMP_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_SELF_JMP) |=> (!s2_vld_q && !s1_vld_q)); // R6
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_STALL) |=> ($stable(s1_vld_q) && $stable(s2_vld_q) && $stable(s2_tgt_q))); // R7
  AST_NO_JUMP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    jump |-> f_valid); // R7
endmodule

// File: rtl/branch_target_predictor.sv
module branch_target_predictor
  import brcache_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned IDX_W  = DEF_IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_vld,
  input  logic              fetch_restart,
  input  logic [ADDR_W-1:0] fetch_pc,
  input  logic              resolve_vld,
  input  logic [ADDR_W-1:0] resolve_pc,
  input  logic              resolve_taken,
  input  logic [ADDR_W-1:0] resolve_tgt,
  output logic              redir_req,
  output logic [ADDR_W-1:0] redir_pc,
  output logic              pred_taken
);
  localparam int unsigned WORD_W = ADDR_W - 2;
  localparam int unsigned TAG_W  = WORD_W - IDX_W;

  logic [WORD_W-1:0] f_word;
  logic [WORD_W-1:0] u_word;
  logic              rd_en;
  logic [IDX_W-1:0]  rd_idx;
  logic              rd_live;
  logic [TAG_W-1:0]  rd_tag;
  logic [WORD_W-1:0] rd_tgt;
  logic              jump;
  logic [WORD_W-1:0] jump_word;

  assign f_word = fetch_pc[ADDR_W-1:2];
  assign u_word = resolve_pc[ADDR_W-1:2];

  brcache_store #(
    .IDX_W (IDX_W),
    .TAG_W (TAG_W),
    .TGT_W (WORD_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (resolve_vld),
    .wr_idx  (u_word[IDX_W-1:0]),
    .wr_tag  (u_word[WORD_W-1:IDX_W]),
    .wr_tgt  (resolve_tgt[ADDR_W-1:2]),
    .wr_live (resolve_taken),
    .rd_en   (rd_en),
    .rd_idx  (rd_idx),
    .rd_live (rd_live),
    .rd_tag  (rd_tag),
    .rd_tgt  (rd_tgt)
  );

  brcache_lookahead #(
    .WORD_W (WORD_W),
    .IDX_W  (IDX_W)
  ) u_look (
    .clk       (clk),
    .rst_n     (rst_n),
    .f_valid   (fetch_vld),
    .f_restart (fetch_restart),
    .f_word    (f_word),
    .rd_en     (rd_en),
    .rd_idx    (rd_idx),
    .rd_live   (rd_live),
    .rd_tag    (rd_tag),
    .rd_tgt    (rd_tgt),
    .jump      (jump),
    .jump_word (jump_word)
  );

  assign redir_req  = jump;
  assign redir_pc   = {jump_word, 2'b00};
  assign pred_taken = jump;

  AST_FETCH_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_vld |-> (fetch_pc[1:0] == 2'b00)); // R1
  AST_RESOLVE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    resolve_vld |-> (resolve_pc[1:0] == 2'b00 && resolve_tgt[1:0] == 2'b00)); // R1
  AST_REDIR_ONLY_ON_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    redir_req |-> (fetch_vld && !fetch_restart)); // R5
endmodule

// File: tb/sim_branch_target_predictor.sv
module sim_branch_target_predictor;
  localparam int AW = 16;
  localparam int IW = 3;
  localparam int N  = 1 << IW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fetch_vld = 1'b0, fetch_restart = 1'b0;
  logic [AW-1:0] fetch_pc = '0;
  logic          resolve_vld = 1'b0, resolve_taken = 1'b0;
  logic [AW-1:0] resolve_pc = '0, resolve_tgt = '0;
  logic          redir_req, pred_taken;
  logic [AW-1:0] redir_pc;

  always #4 clk = ~clk;

  branch_target_predictor #(.ADDR_W(AW), .IDX_W(IW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .fetch_vld(fetch_vld), .fetch_restart(fetch_restart), .fetch_pc(fetch_pc),
    .resolve_vld(resolve_vld), .resolve_pc(resolve_pc),
    .resolve_taken(resolve_taken), .resolve_tgt(resolve_tgt),
    .redir_req(redir_req), .redir_pc(redir_pc), .pred_taken(pred_taken)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int n_redir = 0;
  int pos     = 0;
  bit done    = 1'b0;
  bit            m_live [N];
  logic [AW-1:0] m_pc   [N];
  logic [AW-1:0] m_tgt  [N];
  bit            sn_hit [2];
  logic [AW-1:0] sn_tgt [2];
  logic [AW-1:0] nxt = '0;
  bit            last_redir = 1'b0;

  function automatic int idx(input logic [AW-1:0] a);
    return (int'(a) / 4) % N;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic fv, input logic fr, input logic [AW-1:0] fa,
                     input logic uv, input logic ut, input logic [AW-1:0] upc,
                     input logic [AW-1:0] utg, input string req);
    bit exp;
    bit h;
    logic [AW-1:0] etgt;
    logic [AW-1:0] la;
    int li;
    @(negedge clk);
    fetch_vld = fv; fetch_restart = fr; fetch_pc = fa;
    resolve_vld = uv; resolve_taken = ut; resolve_pc = upc; resolve_tgt = utg;
    #1;
    if (fv) begin
      if (fr) pos = 0;
      exp  = (pos >= 2) && sn_hit[1];
      etgt = sn_tgt[1];
      check(redir_req === exp, req, 32'(redir_req), 32'(exp));
      check(pred_taken === exp, "R8", 32'(pred_taken), 32'(exp));
      if (exp) check(redir_pc === etgt, "R4", 32'(redir_pc), 32'(etgt));
      la = fa + AW'(8);
      li = idx(la);
      h  = m_live[li] && (m_pc[li] == la);
      sn_hit[1] = sn_hit[0]; sn_tgt[1] = sn_tgt[0];
      sn_hit[0] = h;         sn_tgt[0] = m_tgt[li];
      last_redir = exp;
      if (exp) begin n_redir++; nxt = etgt; pos = 0; end
      else begin nxt = fa + AW'(4); pos++; end
    end else begin
      check(redir_req === 1'b0, "R7", 32'(redir_req), 32'd0);
    end
    @(posedge clk);
    #1;
    if (uv) begin
      li = idx(upc);
      m_live[li] = ut; m_pc[li] = upc; m_tgt[li] = utg;
    end
  endtask

  task automatic upd(input logic [AW-1:0] pc, input logic taken, input logic [AW-1:0] tgt);
    cyc(1'b0, 1'b0, '0, 1'b1, taken, pc, tgt, "R3");
  endtask

  task automatic stream(input logic [AW-1:0] start, input int n, input int stall_every, input string req);
    logic [AW-1:0] a;
    a = start;
    n_redir = 0;
    for (int i = 0; i < n; i++) begin
      if (stall_every > 0 && (i % stall_every) == 1)
        cyc(1'b0, 1'b0, '0, 1'b0, 1'b0, '0, '0, "R7");
      cyc(1'b1, (i == 0), a, 1'b0, 1'b0, '0, '0, req);
      a = nxt;
    end
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_live[i] = 1'b0; m_pc[i] = '0; m_tgt[i] = '0; end
    sn_hit[0] = 1'b0; sn_hit[1] = 1'b0; sn_tgt[0] = '0; sn_tgt[1] = '0;
    repeat (3) @(negedge clk);
    check(redir_req === 1'b0 && pred_taken === 1'b0, "R2", 32'(redir_req), 32'd0);
    rst_n = 1'b1;

    // R2: empty table after reset, nothing predicted.
    stream(16'h0100, 16, 0, "R2");
    check(n_redir == 0, "R2", 32'(n_redir), 32'd0);

    // R4/R5: a taken branch at every offset of a restarted stream.
    for (int b = 0; b < N; b++) begin
      upd(AW'(16'h0200 + 4 * b), 1'b1, AW'(16'h0800 + 16 * b));
      stream(16'h0200, 12, 0, "R4");
      check(n_redir == ((b >= 2) ? 1 : 0), "R5", 32'(n_redir), (b >= 2) ? 32'd1 : 32'd0);
      upd(AW'(16'h0200 + 4 * b), 1'b0, AW'(16'h0800 + 16 * b));
      stream(16'h0200, 12, 0, "R3");
      check(n_redir == 0, "R3", 32'(n_redir), 32'd0);
    end

    // R1: same index, different upper bits never hit.
    upd(16'h0210, 1'b1, 16'h0900);
    for (int k = 1; k < 4; k++) begin
      stream(AW'(16'h0208 + 32 * k), 6, 0, "R1");
      check(n_redir == 0, "R1", 32'(n_redir), 32'd0);
    end
    stream(16'h0208, 6, 0, "R1");
    check(n_redir == 1, "R1", 32'(n_redir), 32'd1);
    upd(16'h0210, 1'b0, 16'h0900);

    // R6: chained branches after the block's own jump.
    upd(16'h0308, 1'b1, 16'h0410);
    upd(16'h0410, 1'b1, 16'h0500);
    upd(16'h0418, 1'b1, 16'h0600);
    stream(16'h0300, 12, 0, "R6");
    check(n_redir == 2, "R6", 32'(n_redir), 32'd2);

    // R7: same streams with stall cycles inserted.
    for (int s = 2; s < 5; s++) begin
      stream(16'h0300, 12, s, "R7");
      check(n_redir == 2, "R7", 32'(n_redir), 32'd2);
    end

    for (int i = 0; i < N; i++) upd(AW'(4 * i), 1'b0, '0);

    // R9: kill in the same cycle as the lookahead read is not seen.
    upd(16'h0220, 1'b1, 16'h0700);
    cyc(1'b1, 1'b1, 16'h0210, 1'b0, 1'b0, '0, '0, "R9");
    cyc(1'b1, 1'b0, 16'h0214, 1'b0, 1'b0, '0, '0, "R9");
    cyc(1'b1, 1'b0, 16'h0218, 1'b1, 1'b0, 16'h0220, 16'h0700, "R9");
    cyc(1'b1, 1'b0, 16'h021C, 1'b0, 1'b0, '0, '0, "R9");
    cyc(1'b1, 1'b0, 16'h0220, 1'b0, 1'b0, '0, '0, "R9");
    check(last_redir == 1'b1, "R9", 32'(last_redir), 32'd1);
    // One cycle earlier, the kill is seen.
    upd(16'h0220, 1'b1, 16'h0700);
    cyc(1'b1, 1'b1, 16'h0210, 1'b0, 1'b0, '0, '0, "R9");
    cyc(1'b1, 1'b0, 16'h0214, 1'b1, 1'b0, 16'h0220, 16'h0700, "R9");
    cyc(1'b1, 1'b0, 16'h0218, 1'b0, 1'b0, '0, '0, "R9");
    cyc(1'b1, 1'b0, 16'h021C, 1'b0, 1'b0, '0, '0, "R9");
    cyc(1'b1, 1'b0, 16'h0220, 1'b0, 1'b0, '0, '0, "R9");
    check(last_redir == 1'b0, "R9", 32'(last_redir), 32'd0);

    cyc(1'b0, 1'b0, '0, 1'b0, 1'b0, '0, '0, "R7");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule